// File: doc/BRIEF.md
# Circulating Voice Output Buffer with Leading-Sign Normalizer

This block holds one output word for each of sixteen time-multiplexed voices. The words sit in a sixteen-stage loop that advances by one stage on every clock. The word leaving the last stage is fed back into the first stage, unless a load strobe replaces it with a freshly normalized sample. A downstream converter reads the loop exit once per slot. A second output taps the loop a few stages before the exit.

Each incoming sample is a 15-bit two's-complement value. It is reduced to a 12-bit mantissa plus a one-hot 4-bit scale code. The normalizer counts how many top bits match the sign bit. It then shifts the sample left by 0 to 3 places, always keeping two copies of the sign, and keeps the top 12 bits of the result. The shift amount selects the scale line, so that an external divider can undo the shift. The shift decision takes longer than the data path. For that reason, the five bits it examines are taken straight from the input, while the full sample waits in a delay line. Both paths meet three clocks after the sample is presented.

Top module: `voice_out_buffer`

## Requirements
- R1: After a synchronous active-low reset, every loop stage holds 16'h1000 (mantissa zero, scale line 0 active). With no loads, both outputs show 16'h1000 for the next 16 cycles.
- R2: In a cycle where no word is written, the loop head takes the word that is leaving the loop. A word therefore reappears at the exit every 16 clocks.
- R3: A sample presented together with `smp_load` at clock edge k is written into the loop head at edge k+3. It is visible on `loop_out` after edge k+18.
- R4: The normalizer counts L, the number of leading bits equal to bit 14, looking at bits 14 down to 10 only (so 1 ≤ L ≤ 5). The shift is 3 for L=5, 2 for L=4, 1 for L=3 and 0 for L≤2.
- R5: The mantissa is bits [14:3] of the sample after it is shifted left by the chosen amount. Whenever the shift is not zero, mantissa bits 11 and 10 are equal.
- R6: Word layout: bits [15:12] hold the scale code and bits [11:0] hold the mantissa. The scale code is one-hot, and bit 12+s is set for shift s. Exactly one scale bit is set on every word the loop presents.
- R7: `early_out` shows the word that `loop_out` will present 3 clocks later.
- R8: Sample values presented without `smp_load` have no effect on any stored word.
- R9: Range extremes normalize as follows:
  - 15'h0000 gives 16'h8000.
  - 15'h7FFF (-1) gives 16'h8FFF.
  - 15'h3FFF gives 16'h17FF.
  - 15'h4000 gives 16'h1800.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; loop advances one stage per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_in | input | 15 | Two's-complement voice sample |
| smp_load | input | 1 | Write the normalized `smp_in` into the loop head slot three clocks later |
| loop_out | output | 16 | Word leaving the loop: {scale[3:0], mantissa[11:0]} |
| early_out | output | 16 | Loop word three stages ahead of the exit |

## Verification
On every cycle, the bound checker confirms the following:
- the exit scale code is one-hot;
- normalized words keep two matching sign bits;
- the exit matches the early tap from three clocks before;
- the write strobe trails the load input by three clocks;
- the loop head takes either the new word or the recirculated exit word.

The exact shift chosen for each leading-bit count, the mantissa values, and the 18-cycle path from input to exit can only be shown by the bench. It does this with a cycle-level reference model under random samples, plus directed words at every shift class and the range extremes. The bench also shows that unloaded samples leave stored words untouched and that the reset contents hold for a full loop.

// File: rtl/vb_pkg.sv
// Package: default geometry shared by the voice buffer modules and its checker.
// Assumes: one word per voice; a word is {scale one-hot, mantissa}.
package vb_pkg;
    localparam int VB_VOICES    = 16;  // loop depth, one stage per voice
    localparam int VB_SAMPLE_W  = 15;  // incoming two's-complement sample width
    localparam int VB_MANT_W    = 12;  // stored mantissa width
    localparam int VB_SCALE_W   = 4;   // one-hot scale lines (shift 0..3)
    localparam int VB_KEEP_SIGN = 2;   // sign copies always kept after shifting
    localparam int VB_PIPE_LAT  = 3;   // clocks from sample to loop-head write
    localparam int VB_EARLY     = 3;   // early tap lead over the loop exit
endpackage

// File: rtl/vb_shift_decide.sv
// Module: vb_shift_decide
// Counts how many top probe bits repeat the sign bit and turns the count
// into a left-shift amount that leaves KEEP_SIGN sign copies. The result
// is ready LAT clocks after the probe bits are presented.
// Assumes: PROBE_W = (max shift) + KEEP_SIGN, LAT >= 2.
module vb_shift_decide #(
    parameter int PROBE_W   = 5,
    parameter int KEEP_SIGN = 2,
    parameter int SHAMT_W   = 2,
    parameter int LAT       = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PROBE_W-1:0] probe,
    output logic [SHAMT_W-1:0] shamt
);
    localparam int DLY_N = LAT - 1;

    logic [PROBE_W-1:0] probe_q;
    logic [SHAMT_W-1:0] sh_q [DLY_N];

    // Leading sign-matching bit count, mapped to a shift amount.
    function automatic logic [SHAMT_W-1:0] pick_shift(input logic [PROBE_W-1:0] p);
        int   lead;
        logic run;
        lead = 1;
        run  = 1'b1;
        for (int i = PROBE_W - 2; i >= 0; i--) begin
            if (run && (p[i] == p[PROBE_W-1])) lead++;
            else run = 1'b0;
        end
        if (lead > KEEP_SIGN) return SHAMT_W'(lead - KEEP_SIGN);
        return '0;
    endfunction

    // Capture the early probe bits.
    always_ff @(posedge clk) begin
        if (!rst_n) probe_q <= '0;
        else        probe_q <= probe;
    end

    // Register the decided shift amount.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q[0] <= '0;
        else        sh_q[0] <= pick_shift(probe_q);
    end

    // Extra alignment stages when the latency is above the minimum.
    for (genvar g = 1; g < DLY_N; g++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q[g] <= '0;
            else        sh_q[g] <= sh_q[g-1];
        end
    end

    assign shamt = sh_q[DLY_N-1];
endmodule

// File: rtl/vb_normalize.sv
// Module: vb_normalize
// Delays the full sample to meet the shift decision. It then selects one of
// SCALE_W pre-shifted copies, keeps the top MANT_W bits, and registers the
// packed word {one-hot scale, mantissa}.
// Assumes: shamt arrives aligned with the delayed sample (same DLY).
module vb_normalize #(
    parameter int SAMPLE_W = 15,
    parameter int MANT_W   = 12,
    parameter int SCALE_W  = 4,
    parameter int SHAMT_W  = 2,
    parameter int DLY      = 2,
    parameter int WORD_W   = MANT_W + SCALE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SHAMT_W-1:0]  shamt,
    output logic [WORD_W-1:0]   word
);
    logic [SAMPLE_W-1:0] smp_d [DLY];
    logic [SAMPLE_W-1:0] cand  [SCALE_W];
    logic [MANT_W-1:0]   mant;
    logic [SCALE_W-1:0]  scale;

    // First stage of the sample delay line.
    always_ff @(posedge clk) begin
        if (!rst_n) smp_d[0] <= '0;
        else        smp_d[0] <= sample;
    end

    // Remaining delay stages.
    for (genvar g = 1; g < DLY; g++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n) smp_d[g] <= '0;
            else        smp_d[g] <= smp_d[g-1];
        end
    end

    // One pre-shifted candidate per scale line.
    for (genvar s = 0; s < SCALE_W; s++) begin : g_cand
        assign cand[s] = smp_d[DLY-1] << s;
    end

    // Select the candidate and the matching scale line.
    always_comb begin
        mant  = cand[shamt][SAMPLE_W-1 -: MANT_W];
        scale = SCALE_W'(1) << shamt;
    end

    // Register the packed word; reset gives zero mantissa at unity scale.
    always_ff @(posedge clk) begin
        if (!rst_n) word <= {SCALE_W'(1), MANT_W'(0)};
        else        word <= {scale, mant};
    end
endmodule

// File: rtl/vb_voice_loop.sv
// Module: vb_voice_loop
// DEPTH-stage recirculating shift loop. The head stage takes wr_word when
// wr_en is high and the exiting word otherwise. The head, the exit and a tap
// EARLY stages before the exit are brought out.
// Assumes: EARLY < DEPTH - 1.
module vb_voice_loop #(
    parameter int              DEPTH  = 16,
    parameter int              WORD_W = 16,
    parameter int              EARLY  = 3,
    parameter logic [WORD_W-1:0] RST_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] head_word,
    output logic [WORD_W-1:0] exit_word,
    output logic [WORD_W-1:0] early_word
);
    logic [WORD_W-1:0] stage [DEPTH];

    // Head stage: load a new word or recirculate the exit.
    always_ff @(posedge clk) begin
        if (!rst_n)     stage[0] <= RST_WORD;
        else if (wr_en) stage[0] <= wr_word;
        else            stage[0] <= stage[DEPTH-1];
    end

    // Body stages: advance one position per clock.
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage[g] <= RST_WORD;
            else        stage[g] <= stage[g-1];
        end
    end

    assign head_word  = stage[0];
    assign exit_word  = stage[DEPTH-1];
    assign early_word = stage[DEPTH-1-EARLY];
endmodule

// File: rtl/voice_out_buffer.sv
// Module: voice_out_buffer (top)
// Normalizes each loaded 15-bit sample into {one-hot scale, 12-bit mantissa}
// and stores it in a 16-slot recirculating voice loop. The shift decision
// runs on the top sample bits taken ahead of the delayed main path.
// Assumes: the caller times smp_load to the slot it intends to fill.
module voice_out_buffer
    import vb_pkg::*;
#(
    parameter int VOICES    = VB_VOICES,
    parameter int SAMPLE_W  = VB_SAMPLE_W,
    parameter int MANT_W    = VB_MANT_W,
    parameter int SCALE_W   = VB_SCALE_W,
    parameter int KEEP_SIGN = VB_KEEP_SIGN,
    parameter int PIPE_LAT  = VB_PIPE_LAT,
    parameter int EARLY     = VB_EARLY
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SAMPLE_W-1:0]         smp_in,
    input  logic                        smp_load,
    output logic [MANT_W+SCALE_W-1:0]   loop_out,
    output logic [MANT_W+SCALE_W-1:0]   early_out
);
    localparam int WORD_W   = MANT_W + SCALE_W;
    localparam int MAX_SH   = SCALE_W - 1;
    localparam int PROBE_W  = MAX_SH + KEEP_SIGN;
    localparam int SHAMT_W  = (SCALE_W > 1) ? $clog2(SCALE_W) : 1;
    localparam int DEC_LAT  = PIPE_LAT - 1;
    localparam logic [WORD_W-1:0] RST_WORD = {SCALE_W'(1), MANT_W'(0)};

    logic [SHAMT_W-1:0] shamt;
    logic [WORD_W-1:0]  write_word;
    logic [WORD_W-1:0]  head_word;
    logic               write_en;
    logic               load_q [PIPE_LAT];

    // Shift decision from the early probe bits.
    vb_shift_decide #(
        .PROBE_W(PROBE_W), .KEEP_SIGN(KEEP_SIGN), .SHAMT_W(SHAMT_W), .LAT(DEC_LAT)
    ) u_decide (
        .clk(clk), .rst_n(rst_n),
        .probe(smp_in[SAMPLE_W-1 -: PROBE_W]),
        .shamt(shamt)
    );

    // Delayed main path and shifter.
    vb_normalize #(
        .SAMPLE_W(SAMPLE_W), .MANT_W(MANT_W), .SCALE_W(SCALE_W),
        .SHAMT_W(SHAMT_W), .DLY(DEC_LAT)
    ) u_norm (
        .clk(clk), .rst_n(rst_n),
        .sample(smp_in), .shamt(shamt), .word(write_word)
    );

    // First stage of the load strobe alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) load_q[0] <= 1'b0;
        else        load_q[0] <= smp_load;
    end

    // Remaining load strobe stages, matching the word path.
    for (genvar g = 1; g < PIPE_LAT; g++) begin : g_load
        always_ff @(posedge clk) begin
            if (!rst_n) load_q[g] <= 1'b0;
            else        load_q[g] <= load_q[g-1];
        end
    end

    assign write_en = load_q[PIPE_LAT-1];

    // Recirculating voice storage.
    vb_voice_loop #(
        .DEPTH(VOICES), .WORD_W(WORD_W), .EARLY(EARLY), .RST_WORD(RST_WORD)
    ) u_loop (
        .clk(clk), .rst_n(rst_n),
        .wr_en(write_en), .wr_word(write_word),
        .head_word(head_word), .exit_word(loop_out), .early_word(early_out)
    );
endmodule

// File: rtl/vb_loop_chk.sv
// Module: vb_loop_chk
// Property checker for voice_out_buffer, attached with bind below.
// Assumes: signals are sampled at the rising clock edge; reset is sync active-low.
module vb_loop_chk #(
    parameter int MANT_W   = 12,
    parameter int SCALE_W  = 4,
    parameter int PIPE_LAT = 3,
    parameter int EARLY    = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      smp_load,
    input logic [MANT_W+SCALE_W-1:0] loop_out,
    input logic [MANT_W+SCALE_W-1:0] early_out,
    input logic                      write_en,
    input logic [MANT_W+SCALE_W-1:0] write_word,
    input logic [MANT_W+SCALE_W-1:0] head_word
);
    logic [3:0] since_rst;

    // Count clocks since reset, saturating, to bound the $past windows.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != '1)  since_rst <= since_rst + 4'd1;
    end

    assert_scale_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(loop_out[MANT_W +: SCALE_W]) == 1);

    assert_keep_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (write_word[MANT_W] == 1'b0) |-> (write_word[MANT_W-1] == write_word[MANT_W-2]));

    assert_early_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'(EARLY)) |-> (loop_out == $past(early_out, EARLY)));

    assert_write_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'(PIPE_LAT)) |-> (write_en == $past(smp_load, PIPE_LAT)));

    assert_head_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        write_en |=> (head_word == $past(write_word)));

    assert_head_recirc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !write_en |=> (head_word == $past(loop_out)));
endmodule

bind voice_out_buffer vb_loop_chk #(
    .MANT_W(MANT_W), .SCALE_W(SCALE_W), .PIPE_LAT(PIPE_LAT), .EARLY(EARLY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_load(smp_load),
    .loop_out(loop_out), .early_out(early_out),
    .write_en(write_en), .write_word(write_word), .head_word(head_word)
);

// File: tb/sim_voice_out_buffer.sv
// Bench for voice_out_buffer: reference loop model, random stimulus with a
// fixed seed, and directed normalizer corner words.
module sim_voice_out_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] smp_in = '0;
    logic        smp_load = 1'b0;
    logic [15:0] loop_out, early_out;

    int n_chk = 0;
    int n_fail = 0;
    logic model_on = 1'b0;

    logic [15:0] m_loop [16];
    logic        m_ld   [3];
    logic [15:0] m_wd   [3];
    logic [15:0] m_old;

    always #5 clk = ~clk;

    voice_out_buffer u0 (
        .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_load(smp_load),
        .loop_out(loop_out), .early_out(early_out)
    );

    // Expected word from the R4/R5/R6 rules.
    function automatic logic [15:0] ref_word(input logic [14:0] s);
        int lead;
        int sh;
        logic [14:0] v;
        lead = 1;
        for (int i = 13; i >= 10; i--) begin
            if (s[i] == s[14] && lead == 14 - i) lead = lead + 1;
        end
        sh = (lead > 2) ? lead - 2 : 0;
        v  = s << sh;
        return {4'(1 << sh), v[14:3]};
    endfunction

    function automatic logic [14:0] rand_sample();
        logic signed [14:0] v;
        v = 15'($urandom);
        return v >>> ($urandom % 6);
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Reference model: 3-clock write pipeline feeding a 16-stage loop.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_loop[i] = 16'h1000;
            for (int i = 0; i < 3; i++) begin m_ld[i] = 1'b0; m_wd[i] = 16'h1000; end
        end else begin
            m_old = m_loop[15];
            for (int i = 15; i > 0; i--) m_loop[i] = m_loop[i-1];
            m_loop[0] = m_ld[2] ? m_wd[2] : m_old;
            m_ld[2] = m_ld[1]; m_wd[2] = m_wd[1];
            m_ld[1] = m_ld[0]; m_wd[1] = m_wd[0];
            m_ld[0] = smp_load; m_wd[0] = ref_word(smp_in);
        end
    end

    // Continuous model comparison away from the active edge.
    always @(negedge clk) begin
        if (model_on) begin
            check("R2/R3/R4/R8 loop_out vs model", loop_out, m_loop[15]);
            check("R7 early_out vs model", early_out, m_loop[12]);
        end
    end

    // Load one word, watch it reach the exit, then confirm it survives a lap.
    task automatic load_track(input logic [14:0] s, input logic [15:0] exp, input string tag);
        @(negedge clk); smp_in = s; smp_load = 1'b1;
        @(negedge clk); smp_load = 1'b0; smp_in = rand_sample();
        repeat (18) begin @(negedge clk); smp_in = rand_sample(); end
        check({tag, " R3 word at exit after 18 clocks"}, loop_out, exp);
        repeat (16) begin @(negedge clk); smp_in = rand_sample(); end
        check({tag, " R2/R8 word kept after one lap with unloaded samples"}, loop_out, exp);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset contents for a full lap.
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            check("R1 reset loop_out", loop_out, 16'h1000);
            check("R1 reset early_out", early_out, 16'h1000);
        end
        model_on = 1'b1;
        // Directed shift classes (R4, R5, R6) and extremes (R9).
        load_track(15'h0000, 16'h8000, "R9 zero");
        load_track(15'h7FFF, 16'h8FFF, "R9 minus one");
        load_track(15'h3FFF, 16'h17FF, "R9 max positive");
        load_track(15'h4000, 16'h1800, "R9 max negative");
        load_track(15'h0400, 16'h4200, "R4 R6 positive shift2");
        load_track(15'h7800, 16'h4C00, "R4 R5 negative shift2");
        load_track(15'h7C00, 16'h8C00, "R4 R5 negative shift3");
        load_track(15'h0800, 16'h2200, "R4 R6 positive shift1");
        load_track(15'h1000, 16'h1200, "R4 two sign bits no shift");
        // Random mix across all shift classes.
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            smp_in   = rand_sample();
            smp_load = ($urandom % 2) == 0;
        end
        @(negedge clk); smp_load = 1'b0;
        repeat (20) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule